// File: doc/BRIEF.md
# Protected Clock Source Controller

This block decides which clock drives the CPU and at what post-divide setting. Three sources can be picked: the main crystal clock, an on-chip oscillator clock and a multiplied PLL clock. Software programs the block through a small register bus with a 2-bit address, 8-bit write data, a write strobe and combinational read data. The select, enable and ratio outputs go straight to an external glitch-free clock multiplexer and to the PLL macro.

Configuration is guarded in two ways. First, a lock register must be opened before any clock register accepts a write. Second, the block refuses transitions that would leave the CPU without a valid clock. It will not select the PLL before the PLL has settled, and it will not stop the PLL while the PLL is the CPU source. A refused write leaves every register untouched and raises a sticky error flag. A settle counter starts when the PLL run bit is set and reports the PLL as ready once a fixed number of cycles has passed.

Top module: `clkctl_top`

## Requirements
- R1: After reset the source is main clock (code 00), the divider field is 01000b (divide by 8), loss detection is enabled, the PLL is off with ratio /2, the lock is closed and the error flag is clear.
- R2: Address 0 bit 0 is the unlock bit and can always be written. A write to address 1 or 2 while unlock is 0 is dropped silently: no register changes and no error is raised.
- R3: The divider field sits in bits [7:3] of address 1 and drives `div_code` directly.
- R4: Bit 0 of address 2 is the PLL run bit and drives `pll_en`. `pll_ready` is 0 whenever run is 0.
- R5: `pll_ready` rises exactly SETTLE_CYCLES clock edges after the edge that sets run. Writing run=1 again while it is already 1 does not restart the count.
- R6: A write to address 1 with source code 10 (PLL) while `pll_ready` is 0 is ignored as a whole and sets the error flag. The error flag stays set until reset.
- R7: A write to address 2 with run=0 while the PLL is the selected source is ignored as a whole and sets the error flag.
- R8: Bit 1 of address 2 drives `pll_div3`: 0 selects VCO/2 and 1 selects VCO/3.
- R9: Bit 2 of address 1 drives `loss_det_en`. Software may clear it while moving to the main clock.
- R10: Source code 11 is reserved. A write carrying it is ignored as a whole and sets the error flag.
- R11: Exactly one select output is high: `sel_main` for code 00, `sel_osc` for code 01, `sel_pll` for code 10.
- R12: `rdata` shows the register at `addr` in the same cycle. Address 3 is read-only status: {main_stopped at bit 2, error at bit 1, pll_ready at bit 0}. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe |
| main_stopped | input | 1 | High when the main oscillator is not running |
| rdata | output | 8 | Read data for `addr` |
| sel_main | output | 1 | Select the main clock |
| sel_osc | output | 1 | Select the on-chip oscillator |
| sel_pll | output | 1 | Select the PLL clock |
| pll_en | output | 1 | PLL run enable |
| pll_div3 | output | 1 | PLL output ratio: 0 gives /2, 1 gives /3 |
| pll_ready | output | 1 | PLL settle interval has elapsed |
| div_code | output | 5 | CPU clock post-divider code |
| loss_det_en | output | 1 | Main-clock loss detection enable |

## Verification
The bench builds the block with SETTLE_CYCLES set to 12 rather than the default 4096. With that value the whole countdown fits inside a short run. It also puts a premature PLL select, a mid-count re-write of the run bit and the exact edge at which ready rises within a few dozen cycles, and each of these is compared against a behavioural model on every clock. Both PLL ratios, locked writes and every refused transition are driven over the register bus.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int DIVW = 5;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'b00,
    SRC_OSC  = 2'b01,
    SRC_PLL  = 2'b10,
    SRC_RSVD = 2'b11
  } src_e;

  localparam logic [AW-1:0] A_KEY  = 2'd0;
  localparam logic [AW-1:0] A_SRC  = 2'd1;
  localparam logic [AW-1:0] A_PLL  = 2'd2;
  localparam logic [AW-1:0] A_STAT = 2'd3;

  localparam logic [DIVW-1:0] DIV_RESET = 5'b01000;

  // A source write is legal for main/osc, or for PLL once it has settled.
  function automatic logic src_write_ok(logic [1:0] code, logic ready);
    return (code == SRC_MAIN) || (code == SRC_OSC) || ((code == SRC_PLL) && ready);
  endfunction

  // The PLL may only be stopped while it is not the CPU source.
  function automatic logic pll_write_ok(logic run_new, logic [1:0] cur_src);
    return run_new || (cur_src != SRC_PLL);
  endfunction
endpackage

// File: rtl/clkctl_settle.sv
module clkctl_settle #(
  parameter int SETTLE_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ready
);
  localparam int CW = $clog2(SETTLE_CYCLES + 2);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= LOAD;
    else if (!run)           remain <= LOAD;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign ready = run && (remain == '0);

  assert_ready_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !ready);
  generate
    if (SETTLE_CYCLES > 0) begin : g_chk
      assert_not_ready_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> !ready);
    end
  endgenerate
  assert_ready_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && run) |=> (ready || !run));
endmodule

// File: rtl/clkctl_guard.sv
module clkctl_guard
  import clkctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [1:0]    src_code,
  input  logic          run_new,
  input  logic          unlock,
  input  logic          ready,
  input  logic [1:0]    cur_src,
  output logic          key_commit,
  output logic          src_commit,
  output logic          pll_commit,
  output logic          err_set
);
  logic src_hit, pll_hit, src_ok, pll_ok;

  always_comb begin
    key_commit = we && (addr == A_KEY);
    src_hit    = we && unlock && (addr == A_SRC);
    pll_hit    = we && unlock && (addr == A_PLL);
    src_ok     = src_write_ok(src_code, ready);
    pll_ok     = pll_write_ok(run_new, cur_src);
    src_commit = src_hit && src_ok;
    pll_commit = pll_hit && pll_ok;
    err_set    = (src_hit && !src_ok) || (pll_hit && !pll_ok);
  end

  assert_locked_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock |-> !(src_commit || pll_commit || err_set));
  assert_commit_xor_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !((src_commit || pll_commit) && err_set));
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic [7:0]    wdata,
  input  logic          we,
  input  logic          main_stopped,
  output logic [7:0]    rdata,
  output logic          sel_main,
  output logic          sel_osc,
  output logic          sel_pll,
  output logic          pll_en,
  output logic          pll_div3,
  output logic          pll_ready,
  output logic [4:0]    div_code,
  output logic          loss_det_en
);
  logic            unlock, err, run, ratio, lde;
  logic [1:0]      src;
  logic [DIVW-1:0] div;
  logic            key_commit, src_commit, pll_commit, err_set;

  clkctl_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .run(run), .ready(pll_ready)
  );

  clkctl_guard u_guard (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we),
    .src_code(wdata[1:0]), .run_new(wdata[0]),
    .unlock(unlock), .ready(pll_ready), .cur_src(src),
    .key_commit(key_commit), .src_commit(src_commit),
    .pll_commit(pll_commit), .err_set(err_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock <= 1'b0;
      src    <= SRC_MAIN;
      lde    <= 1'b1;
      div    <= DIV_RESET;
      run    <= 1'b0;
      ratio  <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (key_commit) unlock <= wdata[0];
      if (src_commit) begin
        src <= wdata[1:0];
        lde <= wdata[2];
        div <= wdata[7:3];
      end
      if (pll_commit) begin
        run   <= wdata[0];
        ratio <= wdata[1];
      end
      if (err_set) err <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      A_KEY:   rdata = {7'b0, unlock};
      A_SRC:   rdata = {div, lde, src};
      A_PLL:   rdata = {6'b0, ratio, run};
      default: rdata = {5'b0, main_stopped, err, pll_ready};
    endcase
  end

  assign sel_main    = (src == SRC_MAIN);
  assign sel_osc     = (src == SRC_OSC);
  assign sel_pll     = (src == SRC_PLL);
  assign pll_en      = run;
  assign pll_div3    = ratio;
  assign div_code    = div;
  assign loss_det_en = lde;

  assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_main, sel_osc, sel_pll}) == 1);
  assert_pll_sel_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pll |-> pll_ready);
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_no_stop_under_pll_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pll |=> pll_en);
  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !unlock && addr != A_KEY) |=> $stable({src, lde, div, run, ratio, err}));
endmodule

// File: tb/clkctl_top_bench.sv
module clkctl_top_bench;
  localparam int PERIOD = 10;
  localparam int SETTLE = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic       we = 1'b0;
  logic       main_stopped = 1'b0;
  logic [7:0] rdata;
  logic       sel_main, sel_osc, sel_pll, pll_en, pll_div3, pll_ready, loss_det_en;
  logic [4:0] div_code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  clkctl_top #(.SETTLE_CYCLES(SETTLE)) u_clkctl_top (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
    .main_stopped(main_stopped), .rdata(rdata), .sel_main(sel_main),
    .sel_osc(sel_osc), .sel_pll(sel_pll), .pll_en(pll_en), .pll_div3(pll_div3),
    .pll_ready(pll_ready), .div_code(div_code), .loss_det_en(loss_det_en)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_unlock, m_src, m_lde, m_div, m_run, m_ratio, m_err, m_cnt;

  function automatic int m_ready();
    return (m_run == 1 && m_cnt == 0) ? 1 : 0;
  endfunction

  function automatic int m_rdata(int a);
    case (a)
      0: return m_unlock;
      1: return m_div * 8 + m_lde * 4 + m_src;
      2: return m_ratio * 2 + m_run;
      default: return (main_stopped ? 4 : 0) + m_err * 2 + m_ready();
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_unlock = 0; m_src = 0; m_lde = 1; m_div = 8;
      m_run = 0; m_ratio = 0; m_err = 0; m_cnt = SETTLE;
    end else begin
      int rdy;
      int code;
      rdy = m_ready();
      if (m_run == 0) m_cnt = SETTLE;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (we) begin
        if (addr == 2'd0) m_unlock = wdata[0];
        else if (addr == 2'd1 && m_unlock == 1) begin
          code = wdata[1:0];
          if (code == 0 || code == 1 || (code == 2 && rdy == 1)) begin
            m_src = code; m_lde = wdata[2]; m_div = wdata[7:3];
          end else m_err = 1;
        end else if (addr == 2'd2 && m_unlock == 1) begin
          if (wdata[0] == 1'b0 && m_src == 2) m_err = 1;
          else begin m_run = wdata[0]; m_ratio = wdata[1]; end
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 div_code", div_code, m_div);
      chk("R4 pll_en", pll_en, m_run);
      chk("R5 pll_ready", pll_ready, m_ready());
      chk("R8 pll_div3", pll_div3, m_ratio);
      chk("R9 loss_det_en", loss_det_en, m_lde);
      chk("R11 sel", {sel_main, sel_osc, sel_pll},
          (m_src == 0) ? 4 : (m_src == 1) ? 2 : (m_src == 2) ? 1 : 0);
      chk("R12 rdata", rdata, m_rdata(addr));
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, int exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      addr = 2'(i);
      @(posedge clk); #1;
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset values
    rd_chk("R1 src reg", 2'd1, 8'h44);
    rd_chk("R1 pll reg", 2'd2, 0);
    rd_chk("R1 key reg", 2'd0, 0);
    rd_chk("R1 status", 2'd3, 0);
    chk("R1 sel_main", sel_main, 1);
    // R2 locked writes are dropped with no error
    wr(2'd1, 8'b00011_0_01);
    wr(2'd2, 8'h03);
    rd_chk("R2 src unchanged", 2'd1, 8'h44);
    rd_chk("R2 no error", 2'd3, 0);
    wr(2'd0, 8'h01);
    rd_chk("R2 unlock", 2'd0, 1);
    // R3/R9 osc select with new divider and loss detect off
    wr(2'd1, 8'b00011_0_01);
    rd_chk("R3 src reg", 2'd1, 8'b00011_0_01);
    chk("R9 lde off", loss_det_en, 0);
    // R12 status write has no effect
    wr(2'd3, 8'hFF);
    rd_chk("R12 status", 2'd3, 0);
    // R6 PLL select before ready
    wr(2'd1, 8'b00001_1_10);
    rd_chk("R6 refused", 2'd1, 8'b00011_0_01);
    rd_chk("R6 err set", 2'd3, 2);
    // R5 countdown with ratio /3 (R8)
    wr(2'd2, 8'h03);
    chk("R8 ratio3", pll_div3, 1);
    repeat (4) @(posedge clk);
    #1 wr(2'd2, 8'h03);   // re-write does not restart
    repeat (SETTLE - 6) @(posedge clk);
    #1 chk("R5 not yet", pll_ready, 0);
    @(posedge clk); #1;
    chk("R5 ready edge", pll_ready, 1);
    // select PLL now legal
    wr(2'd1, 8'b00010_1_10);
    chk("R11 sel_pll", sel_pll, 1);
    // R7 stop while selected
    wr(2'd2, 8'h00);
    chk("R7 pll still on", pll_en, 1);
    // R8 ratio change to /2 while running
    wr(2'd2, 8'h01);
    chk("R8 ratio2", pll_div3, 0);
    // R10 reserved code
    wr(2'd1, 8'b00000_0_11);
    rd_chk("R10 refused", 2'd1, 8'b00010_1_10);
    // back to main, stop PLL, R4 ready clears
    main_stopped = 1'b1;
    idle(4);
    main_stopped = 1'b0;
    wr(2'd1, 8'b01000_1_00);
    wr(2'd2, 8'h00);
    chk("R4 ready cleared", pll_ready, 0);
    // restart and lock again
    wr(2'd2, 8'h01);
    idle(SETTLE + 3);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'b00001_0_01);
    rd_chk("R2 locked again", 2'd1, 8'b01000_1_00);
    idle(8);
    done = 1;
    summary();
    $finish;
  end
endmodule